// File: doc/BRIEF.md
# Walking-Token Three-Lane Column Loader

This block fills one display line of column data into a parallel input register. The line has 192 channels of 6 bits each. They are grouped into 64 cells of three adjacent channels. Three 6-bit buses deliver one word per lane on every shift-clock edge. A single token walks along the 64-cell chain, and the cell that holds the token stores the three bus words. Because the chain can walk in either direction, several loaders can be chained end to end. Each side of the block has a token pin, modelled as an input, an output and an output enable. Which side takes the token in and which side hands it on to the next device depends on the direction input.

A small handoff controller follows the token traffic. It has three states. IDLE means no token is in the chain. WALK means at least one token is in the chain. PASS lasts one clock after a token has left the far end, and during it the output-side pin is driven high. The transitions are as follows. IDLE goes to WALK when a token enters. WALK goes to PASS when a token leaves the last cell, and goes back to IDLE when the chain is empty. PASS goes to PASS on another exit, to WALK if tokens remain, and otherwise to IDLE. A rising edge of latch enable forces IDLE from every state.

Top module: `col_token_loader`

## Requirements
- R1: While rst_n is low, all tokens, the whole line register and both token output levels are cleared to 0.
- R2: With dir_right high, a token on lt_in is taken into cell 1 at a clock edge. At each later edge, the cell c that holds a token (c = 0..63 counting from cell 1) stores bus_a into channel 3c+1, bus_b into channel 3c+2 and bus_c into channel 3c+3. Channel n (1-based) occupies line_data bits [(n-1)*6 +: 6].
- R3: A token advances exactly one cell per shift-clock edge, so one token fills all 64 cells on the 64 edges after it enters.
- R4: With dir_right low, a token on rt_in is taken into cell 64 and moves toward cell 1, filling cells in descending order.
- R5: On the edge where a token leaves the last cell in the current direction, the output-side pin is driven high for exactly one clock. That pin is rt_out when dir_right is high and lt_out when it is low.
- R6: The output enable of the input-side pin is always low, and the output-side enable is high (lt_oe = !dir_right, rt_oe = dir_right). The token input on the output side is ignored.
- R7: A rising edge of latch_en clears every token. The clock edge that sees the rise stores nothing, and no channel changes afterwards until a new token enters.
- R8: When a line is only partly loaded before latch enable rises, the channels that were not written keep their previous contents.
- R9: Holding latch_en high clears nothing more after its rising edge, so a token injected while it stays high loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_shift | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_right | input | 1 | 1: walk from cell 1 toward cell 64; 0: walk from cell 64 toward cell 1 |
| lt_in | input | 1 | Left token pin, input level |
| lt_out | output | 1 | Left token pin, output level |
| lt_oe | output | 1 | Left token pin, output enable |
| rt_in | input | 1 | Right token pin, input level |
| rt_out | output | 1 | Right token pin, output level |
| rt_oe | output | 1 | Right token pin, output enable |
| bus_a | input | 6 | Lane A word (channels 1, 4, 7, ...) |
| bus_b | input | 6 | Lane B word (channels 2, 5, 8, ...) |
| bus_c | input | 6 | Lane C word (channels 3, 6, 9, ...) |
| latch_en | input | 1 | Latch enable; its rising edge clears the tokens |
| line_data | output | 1152 | Flat line register, channel 1 in the lowest 6 bits |

## Verification
Two directed full-line walks, one in each direction with fresh random words, show that lanes land in the right channels and that cells fill in the right order. The first and last cells are checked by exact bit position, and the handoff pulse is checked on the exact clock. A partial walk that is cut short by latch enable shows the difference between clearing tokens and clearing data. A second token injected while latch enable stays high shows the difference between edge and level behaviour. A long random phase then mixes direction flips, several tokens in flight, stray levels on the output-side pin and latch pulses. It compares the line and the pins against a bench model on every clock.

// File: rtl/col_pkg.sv
package col_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_PASS = 2'd2
    } hand_state_t;
endpackage

// File: rtl/token_chain.sv
module token_chain #(
    parameter int CELLS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_right,
    input  logic             tok_in,
    input  logic             le_rise,
    output logic [CELLS-1:0] cap_en,
    output logic             exit_evt,
    output logic             any_next
);
    logic [CELLS-1:0] tok;
    logic [CELLS-1:0] nxt;
    logic             exit_now;

    generate
        for (genvar i = 0; i < CELLS; i++) begin : g_cell
            if (i == 0) begin : g_first
                assign nxt[i] = dir_right ? tok_in : tok[i+1];
            end else if (i == CELLS-1) begin : g_last
                assign nxt[i] = dir_right ? tok[i-1] : tok_in;
            end else begin : g_mid
                assign nxt[i] = dir_right ? tok[i-1] : tok[i+1];
            end
        end
    endgenerate

    assign exit_now = dir_right ? tok[CELLS-1] : tok[0];
    assign exit_evt = exit_now & ~le_rise;
    assign any_next = ~le_rise & (|nxt);
    assign cap_en   = le_rise ? '0 : tok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tok <= '0;
        else if (le_rise) tok <= '0;
        else              tok <= nxt;
    end

    // R7
    le_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_rise |=> (cap_en == '0));

    // R3
    tok_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_rise && !tok_in && !exit_now) |=> ($countones(tok) == $past($countones(tok))));
endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
    parameter int CELLS = 64,
    parameter int LANES = 3,
    parameter int WIDTH = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CELLS-1:0]             cap_en,
    input  logic [LANES*WIDTH-1:0]       bus_flat,
    output logic [CELLS*LANES*WIDTH-1:0] line_data
);
    localparam int CELL_BITS = LANES * WIDTH;

    generate
        for (genvar c = 0; c < CELLS; c++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    line_data[c*CELL_BITS +: CELL_BITS] <= '0;
                else if (cap_en[c])
                    line_data[c*CELL_BITS +: CELL_BITS] <= bus_flat;
            end
        end
    endgenerate

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en == '0) |=> $stable(line_data));
endmodule

// File: rtl/handoff_fsm.sv
module handoff_fsm
    import col_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le_rise,
    input  logic exit_evt,
    input  logic any_next,
    output logic pass
);
    hand_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (le_rise) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (any_next) state_nxt = ST_WALK;
                ST_WALK: begin
                    if (exit_evt)      state_nxt = ST_PASS;
                    else if (!any_next) state_nxt = ST_IDLE;
                end
                ST_PASS: begin
                    if (exit_evt)      state_nxt = ST_PASS;
                    else if (any_next) state_nxt = ST_WALK;
                    else               state_nxt = ST_IDLE;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pass = (state == ST_PASS);
    end

    // R5
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_evt |=> (state == ST_PASS));
endmodule

// File: rtl/col_token_loader.sv
module col_token_loader #(
    parameter int CELLS = 64,
    parameter int LANES = 3,
    parameter int WIDTH = 6
) (
    input  logic                         clk_shift,
    input  logic                         rst_n,
    input  logic                         dir_right,
    input  logic                         lt_in,
    output logic                         lt_out,
    output logic                         lt_oe,
    input  logic                         rt_in,
    output logic                         rt_out,
    output logic                         rt_oe,
    input  logic [WIDTH-1:0]             bus_a,
    input  logic [WIDTH-1:0]             bus_b,
    input  logic [WIDTH-1:0]             bus_c,
    input  logic                         latch_en,
    output logic [CELLS*LANES*WIDTH-1:0] line_data
);
    logic                   le_q;
    logic                   le_rise;
    logic                   tok_in;
    logic [CELLS-1:0]       cap_en;
    logic                   exit_evt;
    logic                   any_next;
    logic                   pass;
    logic [LANES*WIDTH-1:0] bus_flat;

    always_ff @(posedge clk_shift or negedge rst_n) begin
        if (!rst_n) le_q <= 1'b0;
        else        le_q <= latch_en;
    end

    assign le_rise  = latch_en & ~le_q;
    assign tok_in   = dir_right ? lt_in : rt_in;
    assign bus_flat = {bus_c, bus_b, bus_a};

    token_chain #(.CELLS(CELLS)) u_chain (
        .clk(clk_shift), .rst_n(rst_n), .dir_right(dir_right), .tok_in(tok_in),
        .le_rise(le_rise), .cap_en(cap_en), .exit_evt(exit_evt), .any_next(any_next)
    );

    lane_bank #(.CELLS(CELLS), .LANES(LANES), .WIDTH(WIDTH)) u_bank (
        .clk(clk_shift), .rst_n(rst_n), .cap_en(cap_en),
        .bus_flat(bus_flat), .line_data(line_data)
    );

    handoff_fsm u_fsm (
        .clk(clk_shift), .rst_n(rst_n), .le_rise(le_rise),
        .exit_evt(exit_evt), .any_next(any_next), .pass(pass)
    );

    assign lt_oe  = ~dir_right;
    assign rt_oe  = dir_right;
    assign lt_out = ~dir_right & pass;
    assign rt_out = dir_right & pass;

    // R6
    pin_role_chk: assert property (@(posedge clk_shift) disable iff (!rst_n)
        !(lt_oe && rt_oe) && !(lt_out && !lt_oe) && !(rt_out && !rt_oe));
endmodule

// File: tb/sim_col_token_loader.sv
module sim_col_token_loader;
    localparam int CELLS = 64;
    localparam int CH    = CELLS * 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, dir_right, lt_in, rt_in, latch_en;
    logic lt_out, lt_oe, rt_out, rt_oe;
    logic [5:0] bus_a, bus_b, bus_c;
    logic [CH*6-1:0] line_data;

    col_token_loader u0 (
        .clk_shift(clk), .rst_n(rst_n), .dir_right(dir_right),
        .lt_in(lt_in), .lt_out(lt_out), .lt_oe(lt_oe),
        .rt_in(rt_in), .rt_out(rt_out), .rt_oe(rt_oe),
        .bus_a(bus_a), .bus_b(bus_b), .bus_c(bus_c),
        .latch_en(latch_en), .line_data(line_data)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [5:0] mdata [CH];
    bit mtok [CELLS];
    bit mpass, mle_q;

    function automatic logic [CH*6-1:0] model_flat();
        logic [CH*6-1:0] v;
        for (int n = 0; n < CH; n++) v[n*6 +: 6] = mdata[n];
        return v;
    endfunction

    function automatic void model_reset();
        for (int n = 0; n < CH; n++) mdata[n] = '0;
        for (int c = 0; c < CELLS; c++) mtok[c] = 1'b0;
        mpass = 1'b0;
        mle_q = 1'b0;
    endfunction

    function automatic void model_edge();
        bit nt [CELLS];
        bit inj;
        if (latch_en && !mle_q) begin
            for (int c = 0; c < CELLS; c++) mtok[c] = 1'b0;
            mpass = 1'b0;
        end else begin
            for (int c = 0; c < CELLS; c++)
                if (mtok[c]) begin
                    mdata[3*c]   = bus_a;
                    mdata[3*c+1] = bus_b;
                    mdata[3*c+2] = bus_c;
                end
            inj = dir_right ? lt_in : rt_in;
            mpass = dir_right ? mtok[CELLS-1] : mtok[0];
            for (int c = 0; c < CELLS; c++) begin
                if (dir_right) nt[c] = (c == 0) ? inj : mtok[c-1];
                else           nt[c] = (c == CELLS-1) ? inj : mtok[c+1];
            end
            for (int c = 0; c < CELLS; c++) mtok[c] = nt[c];
        end
        mle_q = latch_en;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_line(input string req);
        checks++;
        if (line_data !== model_flat()) begin
            failures++;
            $display("FAIL %s line mismatch actual=%0h expected=%0h", req, line_data, model_flat());
        end
    endtask

    task automatic chk_pins(input string req);
        chk(req, {60'd0, lt_oe, rt_oe, lt_out, rt_out},
            {60'd0, !dir_right, dir_right, !dir_right && mpass, dir_right && mpass});
    endtask

    task automatic step(input logic dir, input logic lin, input logic rin, input logic le);
        @(negedge clk);
        dir_right = dir; lt_in = lin; rt_in = rin; latch_en = le;
        bus_a = 6'($urandom()); bus_b = 6'($urandom()); bus_c = 6'($urandom());
        @(posedge clk);
        model_edge();
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [5:0] fa, fb, fc;
        void'($urandom(32'd2024));
        rst_n = 1'b0; dir_right = 1'b1; lt_in = 1'b0; rt_in = 1'b0; latch_en = 1'b0;
        bus_a = '0; bus_b = '0; bus_c = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 line", 64'(line_data == '0), 64'd1);
        chk("R1 pins", {60'd0, lt_out, rt_out, lt_oe, rt_oe}, 64'h1);
        @(negedge clk); rst_n = 1'b1;

        // R2 R3 R5 R6: full walk rightward, stray level on rt_in ignored
        step(1'b1, 1'b1, 1'b1, 1'b0);
        for (int k = 0; k < CELLS; k++) begin
            step(1'b1, 1'b0, 1'($urandom() % 2), 1'b0);
            if (k == 0) begin fa = bus_a; fb = bus_b; fc = bus_c; end
            chk("R6 oe", {62'd0, lt_oe, rt_oe}, 64'h1);
            if (k < CELLS-1) chk("R5 no early", 64'(rt_out), 64'd0);
        end
        chk("R2 cell1 lanes", 64'(line_data[17:0]), 64'({fc, fb, fa}));
        chk("R3 cell64 lane A", 64'(line_data[189*6 +: 6]), 64'(bus_a));
        chk("R5 right pulse", {62'd0, lt_out, rt_out}, 64'h1);
        chk_line("R3 full right line");
        step(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 pulse one clock", 64'(rt_out), 64'd0);

        // R4 leftward walk
        step(1'b0, 1'($urandom() % 2), 1'b1, 1'b0);
        for (int k = 0; k < CELLS; k++) begin
            step(1'b0, 1'b0, 1'b0, 1'b0);
            if (k == 0) begin fa = bus_a; fb = bus_b; fc = bus_c; end
            chk("R6 oe left", {62'd0, lt_oe, rt_oe}, 64'h2);
        end
        chk("R4 cell64 first", 64'(line_data[189*6 +: 18]), 64'({fc, fb, fa}));
        chk("R4 cell1 last", 64'(line_data[5:0]), 64'(bus_a));
        chk("R5 left pulse", {62'd0, lt_out, rt_out}, 64'h2);
        chk_line("R4 full left line");
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 left one clock", 64'(lt_out), 64'd0);

        // R7 R8 partial line cut by latch enable
        step(1'b1, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 20; k++) step(1'b1, 1'b0, 1'b0, 1'b0);
        chk_line("R8 partial before latch");
        step(1'b1, 1'b0, 1'b0, 1'b1);
        chk_line("R7 rise edge stores nothing");
        for (int k = 0; k < 10; k++) step(1'b1, 1'b0, 1'b0, 1'b1);
        chk_line("R8 untouched channels kept");
        chk("R7 no pulse", 64'(rt_out), 64'd0);

        // R9 token injected while latch enable stays high
        step(1'b1, 1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R9 loads under held LE", 64'(line_data[4*18 +: 18]), 64'({bus_c, bus_b, bus_a}));
        chk_line("R9 line");
        step(1'b1, 1'b0, 1'b0, 1'b0);

        // random mix: R2 R4 R5 R7 against bench model
        begin
            logic d, l;
            d = 1'b1; l = 1'b0;
            for (int k = 0; k < 600; k++) begin
                if ($urandom() % 40 == 0) d = ~d;
                if ($urandom() % 25 == 0) l = ~l;
                step(d, 1'($urandom() % 23 == 0), 1'($urandom() % 23 == 0), l);
                chk_line("R2 R4 R7 random line");
                chk_pins("R5 R6 random pins");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule